// File: doc/BRIEF.md
# Interrupt Vector Table Indexer

This block finds the gate entry for an interrupt vector inside an in-memory interrupt table. It is also the first check that the entry is usable. A vector presented with its strobe is scaled by the entry size, which is 8 bytes in the narrow legacy mode and 16 bytes in long mode. The scaled offset is added to the table base to form the byte address of the entry. The last byte of the entry is checked against the table's 16-bit limit. An entry that lies past the limit ends the request at once with a general-protection fault. An entry inside the limit is announced with a one-cycle fetch request, and the block then waits for the memory side to return the entry's 4-bit type field.

When the type field arrives, it is sorted into a gate kind. Only task, interrupt and trap gates are accepted; any other type ends the request with a fault. Every fault carries an error code made from the vector: the vector sits at bits 10:3 and bit 1 is set to mark an interrupt-table reference. The block handles one vector at a time. While it waits for a type field, new vectors are not accepted.

Top module: `ivt_indexer`

## Requirements
- R1: In legacy mode (`long_mode`=0) the entry address is `(tbl_base[31:0] + vec*8) mod 2^32`. Address bits 63:32 read zero whatever `tbl_base[63:32]` holds.
- R2: In long mode the entry address is `(tbl_base + vec*16) mod 2^64`.
- R3: An accepted vector whose entry end `vec*size + size - 1` is above `tbl_limit` produces, on the next cycle, `done`=1 and `gp_fault`=1 with no `fetch_req`, and the block stays idle. An end exactly equal to the limit is in range.
- R4: An accepted in-range vector produces, on the next cycle, `entry_addr` and a single-cycle `fetch_req`. `busy` then stays 1 until a type field is returned.
- R5: A returned type of 4'h5, 4'h6, 4'h7, 4'hE or 4'hF gives, on the cycle after `desc_valid`, `done`=1, `gp_fault`=0 and `gate_kind` 1, 2, 3, 4 or 5 (task, 16-bit interrupt, 16-bit trap, wide interrupt, wide trap). `busy` returns to 0 on that cycle.
- R6: Any other returned type gives `done`=1, `gp_fault`=1 and `gate_kind`=0.
- R7: On a faulting `done`, `err_code` equals `(vec << 3) | 2`. On every other cycle `err_code` is 0. `gate_kind` is 0 whenever `done` is 0.
- R8: `vec_valid` is ignored while `busy` is 1, and `entry_addr` does not change then. `desc_valid` is ignored while `busy` is 0, so no `done` follows it.
- R9: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid | input | 1 | Vector strobe |
| vec | input | 8 | Interrupt vector number |
| long_mode | input | 1 | 1 selects 16-byte entries and the full-width base |
| tbl_base | input | 64 | Table base byte address |
| tbl_limit | input | 16 | Table limit in bytes |
| desc_valid | input | 1 | Returned type field is valid |
| desc_type | input | 4 | Type field of the fetched entry |
| entry_addr | output | 64 | Byte address of the entry |
| fetch_req | output | 1 | One-cycle request to read the entry |
| busy | output | 1 | Waiting for the type field |
| done | output | 1 | Request finished this cycle |
| gp_fault | output | 1 | General-protection fault, valid with done |
| gate_kind | output | 3 | Accepted gate kind, valid with done |
| err_code | output | 16 | Fault error code, valid with a faulting done |

## Verification
The hardest cases are the edges of the limit comparison and the wrap of the address sum. They need exact pairings of vector, mode and limit: a limit equal to the entry end and one byte below it, in both modes, and bases close enough to the top of the 32-bit or 64-bit range that the sum carries out. The stimulus sets up these pairings directly. It also asserts `vec_valid` and `desc_valid` in the wrong phase, so the ignored inputs are exercised. A long random stretch then mixes modes, limits and response delays. Every cycle is compared with a behavioural model.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [2:0] {
        GK_NONE   = 3'd0,
        GK_TASK   = 3'd1,
        GK_INT16  = 3'd2,
        GK_TRAP16 = 3'd3,
        GK_INT    = 3'd4,
        GK_TRAP   = 3'd5
    } gate_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } ivt_state_e;

endpackage

// File: rtl/ivt_addr_calc.sv
module ivt_addr_calc #(
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 64,
    parameter int LEGACY_W = 32,
    parameter int LIM_W    = 16
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic              long_mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [LIM_W-1:0]  limit,
    output logic [ADDR_W-1:0] addr,
    output logic              over_limit
);
    localparam int SHORT_SH = 3;
    localparam int LONG_SH  = 4;
    localparam int OFF_W    = VEC_W + LONG_SH;
    localparam int CMP_W    = (OFF_W + 1 > LIM_W) ? OFF_W + 1 : LIM_W;

    logic [OFF_W-1:0]  offset;
    logic [CMP_W-1:0]  last_byte;
    logic [ADDR_W-1:0] base_eff;
    logic [ADDR_W-1:0] sum_full;

    always_comb begin
        offset    = long_mode ? (OFF_W'(vec) << LONG_SH) : (OFF_W'(vec) << SHORT_SH);
        last_byte = CMP_W'(offset) + (long_mode ? CMP_W'((1 << LONG_SH) - 1)
                                                : CMP_W'((1 << SHORT_SH) - 1));
        over_limit = last_byte > CMP_W'(limit);
        sum_full   = base_eff + ADDR_W'(offset);
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < LEGACY_W) begin : g_low
            assign base_eff[i] = base[i];
            assign addr[i]     = sum_full[i];
        end else begin : g_high
            assign base_eff[i] = base[i] & long_mode;
            assign addr[i]     = sum_full[i] & long_mode;
        end
    end
endmodule

// File: rtl/ivt_gate_check.sv
module ivt_gate_check
    import ivt_pkg::*;
#(
    parameter int TYPE_W = 4
) (
    input  logic [TYPE_W-1:0] gtype,
    output gate_kind_e        kind,
    output logic              bad
);
    always_comb begin
        case (gtype)
            TYPE_W'(4'h5): kind = GK_TASK;
            TYPE_W'(4'h6): kind = GK_INT16;
            TYPE_W'(4'h7): kind = GK_TRAP16;
            TYPE_W'(4'hE): kind = GK_INT;
            TYPE_W'(4'hF): kind = GK_TRAP;
            default:       kind = GK_NONE;
        endcase
        bad = (kind == GK_NONE);
    end
endmodule

// File: rtl/ivt_indexer.sv
module ivt_indexer
    import ivt_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int ADDR_W   = 64,
    parameter int LEGACY_W = 32,
    parameter int LIM_W    = 16,
    parameter int TYPE_W   = 4,
    parameter int ERR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec,
    input  logic              long_mode,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LIM_W-1:0]  tbl_limit,
    input  logic              desc_valid,
    input  logic [TYPE_W-1:0] desc_type,
    output logic [ADDR_W-1:0] entry_addr,
    output logic              fetch_req,
    output logic              busy,
    output logic              done,
    output logic              gp_fault,
    output logic [2:0]        gate_kind,
    output logic [ERR_W-1:0]  err_code
);
    localparam logic [2:0] TBL_FLAG = 3'b010;

    typedef struct packed {
        ivt_state_e        state;
        logic              long_m;
        logic [VEC_W-1:0]  vec;
        logic [ADDR_W-1:0] addr;
        logic              fetch;
        logic              done;
        logic              gp;
        gate_kind_e        kind;
        logic [ERR_W-1:0]  err;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] calc_addr;
    logic              calc_over;
    gate_kind_e        chk_kind;
    logic              chk_bad;

    ivt_addr_calc #(
        .VEC_W(VEC_W), .ADDR_W(ADDR_W), .LEGACY_W(LEGACY_W), .LIM_W(LIM_W)
    ) u_addr (
        .vec(vec), .long_mode(long_mode), .base(tbl_base), .limit(tbl_limit),
        .addr(calc_addr), .over_limit(calc_over)
    );

    ivt_gate_check #(.TYPE_W(TYPE_W)) u_gate (
        .gtype(desc_type), .kind(chk_kind), .bad(chk_bad)
    );

    always_comb begin
        r_d       = r_q;
        r_d.fetch = 1'b0;
        r_d.done  = 1'b0;
        r_d.gp    = 1'b0;
        r_d.kind  = GK_NONE;
        r_d.err   = '0;
        case (r_q.state)
            ST_IDLE: begin
                if (vec_valid) begin
                    r_d.vec    = vec;
                    r_d.long_m = long_mode;
                    r_d.addr   = calc_addr;
                    if (calc_over) begin
                        r_d.done = 1'b1;
                        r_d.gp   = 1'b1;
                        r_d.err  = ERR_W'({vec, TBL_FLAG});
                    end else begin
                        r_d.fetch = 1'b1;
                        r_d.state = ST_WAIT;
                    end
                end
            end
            default: begin
                if (desc_valid) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.kind  = chk_kind;
                    r_d.gp    = chk_bad;
                    r_d.err   = chk_bad ? ERR_W'({r_q.vec, TBL_FLAG}) : '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, kind: GK_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign entry_addr = r_q.addr;
    assign fetch_req  = r_q.fetch;
    assign busy       = (r_q.state == ST_WAIT);
    assign done       = r_q.done;
    assign gp_fault   = r_q.gp;
    assign gate_kind  = r_q.kind;
    assign err_code   = r_q.err;

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |=> !fetch_req); // R4
    AST_FETCH_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (busy && !done)); // R4
    AST_FAULT_NO_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (done && gp_fault) |-> (gate_kind == 3'd0)); // R6
    AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && gp_fault) |-> (err_code == '0)); // R7
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_WAIT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(entry_addr)); // R8
    AST_LEGACY_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !r_q.long_m) |-> (entry_addr[ADDR_W-1:LEGACY_W] == '0)); // R1
endmodule

// File: tb/ivt_indexer_tb.sv
module ivt_indexer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_valid = 1'b0;
    logic [7:0]  vec = '0;
    logic        long_mode = 1'b0;
    logic [63:0] tbl_base = '0;
    logic [15:0] tbl_limit = '0;
    logic        desc_valid = 1'b0;
    logic [3:0]  desc_type = '0;
    logic [63:0] entry_addr;
    logic        fetch_req, busy, done, gp_fault;
    logic [2:0]  gate_kind;
    logic [15:0] err_code;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string tag = "R9";

    // behavioural reference state
    logic [63:0] m_addr = '0;
    bit          m_fetch = 0, m_busy = 0, m_done = 0, m_gp = 0;
    int          m_kind = 0, m_err = 0;
    int          m_vec = 0;

    always #5 clk = ~clk;

    ivt_indexer u_dut (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec(vec),
        .long_mode(long_mode), .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .desc_valid(desc_valid), .desc_type(desc_type),
        .entry_addr(entry_addr), .fetch_req(fetch_req), .busy(busy),
        .done(done), .gp_fault(gp_fault), .gate_kind(gate_kind), .err_code(err_code)
    );

    function automatic int kind_of(input int t);
        if (t == 5)  return 1;
        if (t == 6)  return 2;
        if (t == 7)  return 3;
        if (t == 14) return 4;
        if (t == 15) return 5;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr = '0; m_fetch = 0; m_busy = 0; m_done = 0;
            m_gp = 0; m_kind = 0; m_err = 0; m_vec = 0;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            m_fetch = 0; m_done = 0; m_gp = 0; m_kind = 0; m_err = 0;
            if (was_busy) begin
                if (desc_valid) begin
                    m_busy = 0;
                    m_done = 1;
                    m_kind = kind_of(int'(desc_type));
                    m_gp   = (m_kind == 0);
                    m_err  = m_gp ? (m_vec * 8 + 2) : 0;
                end
            end else if (vec_valid) begin
                int size;
                size  = long_mode ? 16 : 8;
                m_vec = int'(vec);
                if (long_mode)
                    m_addr = tbl_base + 64'(m_vec * size);
                else
                    m_addr = {32'h0, tbl_base[31:0] + 32'(m_vec * size)};
                if (m_vec * size + size - 1 > int'(tbl_limit)) begin
                    m_done = 1; m_gp = 1; m_err = m_vec * 8 + 2;
                end else begin
                    m_fetch = 1; m_busy = 1;
                end
            end
        end
    end

    task automatic compare();
        checks++;
        if (entry_addr !== m_addr || fetch_req !== m_fetch || busy !== m_busy ||
            done !== m_done || gp_fault !== m_gp || int'(gate_kind) != m_kind ||
            int'(err_code) != m_err) begin
            fails++;
            $display("FAIL %s t=%0t actual addr=%h fetch=%b busy=%b done=%b gp=%b kind=%0d err=%h expected addr=%h fetch=%b busy=%b done=%b gp=%b kind=%0d err=%h",
                     tag, $time, entry_addr, fetch_req, busy, done, gp_fault, gate_kind, err_code,
                     m_addr, m_fetch, m_busy, m_done, m_gp, m_kind, m_err[15:0]);
        end
    endtask

    task automatic step(input bit vv, input logic [7:0] v, input bit dv, input logic [3:0] t);
        @(negedge clk);
        compare();
        vec_valid = vv; vec = v; desc_valid = dv; desc_type = t;
    endtask

    task automatic cfg(input bit lm, input logic [63:0] b, input logic [15:0] l);
        @(negedge clk);
        compare();
        vec_valid = 0; desc_valid = 0;
        long_mode = lm; tbl_base = b; tbl_limit = l;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h0, 0, 4'h0);
    endtask

    task automatic request(input logic [7:0] v, input logic [3:0] t);
        step(1, v, 0, 4'h0);
        step(0, 8'h0, 0, 4'h0);
        step(0, 8'h0, 1, t);
        step(0, 8'h0, 0, 4'h0);
        step(0, 8'h0, 0, 4'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tag = "R9";
        idle(2);
        rst_n = 1'b1;
        idle(2);

        tag = "R1";
        cfg(0, 64'hDEAD_BEEF_0000_1000, 16'h03FF);
        request(8'h20, 4'hE);
        cfg(0, 64'hFFFF_0000_FFFF_FFF8, 16'hFFFF);
        request(8'h02, 4'h6);

        tag = "R2";
        cfg(1, 64'h1234_5678_9ABC_0000, 16'h0FFF);
        request(8'hFF, 4'hF);
        cfg(1, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0FFF);
        request(8'h01, 4'h5);

        tag = "R3";
        cfg(0, 64'h0000_0000_0000_2000, 16'h03FF);
        request(8'h80, 4'hE);
        cfg(0, 64'h0000_0000_0000_2000, 16'h0407);
        request(8'h80, 4'hE);
        cfg(0, 64'h0000_0000_0000_2000, 16'h0406);
        request(8'h80, 4'hE);
        cfg(1, 64'h0000_0000_0000_2000, 16'h0FFE);
        request(8'hFF, 4'hE);
        cfg(1, 64'h0, 16'h0000);
        request(8'h00, 4'hE);

        tag = "R4";
        cfg(1, 64'h0000_0000_0040_0000, 16'hFFFF);
        step(1, 8'h33, 0, 4'h0);
        idle(6);
        step(0, 8'h0, 1, 4'h7);
        idle(2);

        tag = "R5";
        cfg(0, 64'h0000_0000_0001_0000, 16'hFFFF);
        for (int t = 0; t < 16; t++) begin
            if (kind_of(t) != 0) request(8'(t + 16), 4'(t));
        end
        tag = "R6";
        for (int t = 0; t < 16; t++) begin
            if (kind_of(t) == 0) request(8'(t + 64), 4'(t));
        end

        tag = "R7";
        cfg(1, 64'h0, 16'h00FF);
        request(8'hFF, 4'h0);
        request(8'h05, 4'h3);

        tag = "R8";
        cfg(1, 64'h0000_0000_0000_8000, 16'hFFFF);
        step(0, 8'h0, 1, 4'hE);
        step(0, 8'h0, 1, 4'hF);
        idle(1);
        step(1, 8'h10, 0, 4'h0);
        step(1, 8'h20, 0, 4'h0);
        step(1, 8'h30, 0, 4'h0);
        step(0, 8'h0, 1, 4'hE);
        idle(2);

        tag = "R2";
        for (int i = 0; i < 400; i++) begin
            if (i % 17 == 0)
                cfg(($urandom % 2) == 1, {$urandom, $urandom}, 16'($urandom % 4500));
            step(($urandom % 3) != 0, 8'($urandom), ($urandom % 3) == 0, 4'($urandom));
        end
        idle(3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule